// File: doc/BRIEF.md
# Synchronous Residual Timestamp Generator

This block produces a 4-bit synchronous residual timestamp for a constant-bit-rate circuit-emulation stream. A network reference tick is derived by dividing a line-clock enable by 64. A free-running 4-bit residual counter advances on that reference tick. A second counter counts service-clock bits at the E1/T1 rate. Each time it completes a period of 3008 bits, which is eight SAR payloads, the residual counter value is captured into a holding register.

The captured code is always visible on a byte-wide read port. The code sits in the low nibble and the high nibble reads as zero. A one-cycle strobe marks every fresh capture. The code stream has no back-pressure. The strobe acts as the valid signal and the consumer is taken to be always ready. A code stays on the port until the next capture replaces it, so a consumer may read it at any time within that period.

Both ticks are clock enables within one clock domain.

Top module: `srts_stamp_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `code_byte` is 0x00 and `code_new` is low.
- R2: The residual counter advances by one for every 64 line-clock enables, counted across any gaps in `line_tick_en`.
- R3: The residual counter is 4 bits wide and wraps from 15 to 0 without stopping.
- R4: A capture happens on the clock edge where the 3008th service bit since reset or since the last capture is accepted. In the cycle after that edge, `code_new` is high for exactly one cycle.
- R5: `code_byte` changes only in cycles where `code_new` is high.
- R6: `code_byte[3:0]` holds the captured residual, with bit 0 as the least significant bit and bit 3 as the most significant bit. `code_byte[7:4]` is always zero.
- R7: The value captured is the residual as it stood before the capturing edge. This holds even when a reference tick occurs on the same edge.
- R8: Reset clears the prescaler, the residual counter, the bit counter and the held code. No strobe appears until a full 3008-bit period has elapsed after reset.
- R9: Cycles with `svc_bit_en` low do not count toward the period. Cycles with `line_tick_en` low do not advance the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick_en | input | 1 | One pulse per line-clock period |
| svc_bit_en | input | 1 | One pulse per service-clock bit (E1/T1 rate) |
| code_byte | output | 8 | Held residual code in the low nibble; high nibble is zero |
| code_new | output | 1 | One-cycle strobe: a new code was captured |

## Verification
The first pattern holds both enables high from reset. This puts a reference tick on the same edge as the first capture, so it separates a capture taken before the increment from one taken after it. It also pins the exact bit count, because 3008 is a whole multiple of 64. Random patterns follow with sparse service bits and dense, gapped line ticks. They show that gaps in either enable are skipped rather than counted, and they run the residual counter through many wraps between captures. A long stretch with no service bits confirms that nothing is captured without service bits. A reset in the middle of a period confirms that the period restarts from zero rather than carrying over a partial count.

// File: rtl/srts_pkg.sv
package srts_pkg;
  localparam int unsigned DEF_CODE_W      = 4;
  localparam int unsigned DEF_LINE_DIV    = 64;
  localparam int unsigned DEF_PERIOD_BITS = 3008;
  localparam int unsigned DEF_BYTE_W      = 8;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit <= 2) ? 1 : $clog2(limit);
  endfunction
endpackage

// File: rtl/srts_ref_prescaler.sv
module srts_ref_prescaler
  import srts_pkg::*;
#(
  parameter int unsigned DIV = DEF_LINE_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_en,
  output logic ref_tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign ref_tick = line_en;
    end else begin : g_div
      localparam int unsigned PW = cnt_width(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      assign ref_tick = line_en && (pre_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (line_en) begin
          pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/srts_residual_ctr.sv
module srts_residual_ctr
  import srts_pkg::*;
#(
  parameter int unsigned W = DEF_CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (tick) begin
      value <= value + 1'b1;
    end
  end
endmodule

// File: rtl/srts_period_div.sv
module srts_period_div
  import srts_pkg::*;
#(
  parameter int unsigned N = DEF_PERIOD_BITS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  output logic done
);
  localparam int unsigned BW = cnt_width(N);
  localparam logic [BW-1:0] LAST = BW'(N - 1);
  logic [BW-1:0] bits_q;

  assign done = bit_en && (bits_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (bit_en) begin
      bits_q <= done ? '0 : bits_q + 1'b1;
    end
  end
endmodule

// File: rtl/srts_stamp_hold.sv
module srts_stamp_hold
  import srts_pkg::*;
#(
  parameter int unsigned W      = DEF_CODE_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [W-1:0]      residual,
  output logic [BYTE_W-1:0] byte_out,
  output logic              strobe
);
  localparam int unsigned PAD = BYTE_W - W;
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= capture;
      if (capture) held_q <= residual;
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      assign byte_out = {{PAD{1'b0}}, held_q};
    end else begin : g_nopad
      assign byte_out = held_q[BYTE_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/srts_stamp_gen.sv
module srts_stamp_gen
  import srts_pkg::*;
#(
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned LINE_DIV    = DEF_LINE_DIV,
  parameter int unsigned PERIOD_BITS = DEF_PERIOD_BITS,
  parameter int unsigned BYTE_W      = DEF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick_en,
  input  logic              svc_bit_en,
  output logic [BYTE_W-1:0] code_byte,
  output logic              code_new
);
  logic              ref_tick;
  logic [CODE_W-1:0] residual;
  logic              period_done;

  srts_ref_prescaler #(.DIV(LINE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .line_en(line_tick_en), .ref_tick(ref_tick)
  );

  srts_residual_ctr #(.W(CODE_W)) u_res (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .value(residual)
  );

  srts_period_div #(.N(PERIOD_BITS)) u_per (
    .clk(clk), .rst_n(rst_n), .bit_en(svc_bit_en), .done(period_done)
  );

  srts_stamp_hold #(.W(CODE_W), .BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(period_done), .residual(residual),
    .byte_out(code_byte), .strobe(code_new)
  );
endmodule

// File: rtl/srts_stamp_gen_chk.sv
module srts_stamp_gen_chk
  import srts_pkg::*;
#(
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned PERIOD_BITS = DEF_PERIOD_BITS,
  parameter int unsigned BYTE_W      = DEF_BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              svc_bit_en,
  input logic [BYTE_W-1:0] code_byte,
  input logic              code_new
);
  localparam int unsigned SW = $clog2(PERIOD_BITS + 1);
  localparam logic [SW-1:0] FULL = SW'(PERIOD_BITS);
  logic [SW-1:0] seen_q;

  // Counts service bits since reset, saturating at one full period.
  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (svc_bit_en && seen_q != FULL) seen_q <= seen_q + 1'b1;
  end

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_byte[BYTE_W-1:CODE_W] == '0);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_new |=> !code_new);

  assert_strobe_after_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    code_new |-> $past(svc_bit_en));

  assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !code_new |-> $stable(code_byte));

  assert_no_early_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    code_new |-> seen_q == FULL);
endmodule

bind srts_stamp_gen srts_stamp_gen_chk #(
  .CODE_W(CODE_W), .PERIOD_BITS(PERIOD_BITS), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .svc_bit_en(svc_bit_en),
  .code_byte(code_byte), .code_new(code_new)
);

// File: tb/test_srts_stamp_gen.sv
`timescale 1ns/1ps
module test_srts_stamp_gen;
  localparam int DIV = 64;
  localparam int N   = 3008;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_tick_en = 1'b0;
  logic       svc_bit_en = 1'b0;
  logic [7:0] code_byte;
  logic       code_new;

  int checks = 0;
  int errors = 0;
  int lines = 0;
  int bits = 0;
  int captures = 0;
  logic [3:0] exp_code = 4'h0;
  logic exp_new = 1'b0;
  string phase = "R4";
  bit finished = 0;

  always #2.5 clk = ~clk;

  srts_stamp_gen i_srts_stamp_gen (
    .clk(clk), .rst_n(rst_n), .line_tick_en(line_tick_en),
    .svc_bit_en(svc_bit_en), .code_byte(code_byte), .code_new(code_new)
  );

  function automatic logic [3:0] residual_of(input int n_lines);
    return 4'((n_lines / DIV) % 16);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_clear();
    lines = 0; bits = 0; exp_code = 4'h0; exp_new = 1'b0;
  endtask

  // Called at a negedge: drive, take the edge, update the model, check at the next negedge.
  task automatic step(input logic l, input logic s);
    logic done_m;
    line_tick_en = l;
    svc_bit_en = s;
    @(posedge clk);
    done_m = s && (bits == N - 1);
    if (done_m) begin
      exp_code = residual_of(lines);   // R7: value before the edge
      captures++;
    end
    exp_new = done_m;
    lines += int'(l);
    if (s) bits = done_m ? 0 : bits + 1;
    @(negedge clk);
    check(exp_new ? "R4" : phase, int'(code_new), int'(exp_new));
    check(exp_new ? "R2/R3 captured value" : "R5 hold", int'(code_byte[3:0]), int'(exp_code));
    check("R6 upper nibble", int'(code_byte[7:4]), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line_tick_en = 1'b0;
    svc_bit_en = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
    check("R1 byte in reset", int'(code_byte), 0);
    check("R1 strobe in reset", int'(code_new), 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    check("R1 byte after reset", int'(code_byte), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    @(negedge clk);
    do_reset();

    // Directed: both enables high, so a reference tick lands on the capture edge (R7).
    phase = "R8";
    for (int i = 0; i < N - 1; i++) step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    check("R7 same-edge capture", int'(code_byte[3:0]), 14);
    check("R4 strobe at bit 3008", int'(code_new), 1);
    phase = "R4";
    for (int i = 0; i < N; i++) step(1'b1, 1'b1);
    check("R7 second capture", int'(code_byte[3:0]), 13);

    // R9: no service bits for a long stretch -> no capture, value held.
    phase = "R9";
    for (int i = 0; i < 4000; i++) step(1'b1, 1'b0);
    check("R9 code unchanged", int'(code_byte[3:0]), 13);

    // Random: gapped line ticks, sparse service bits (R2, R3, R9).
    phase = "R4";
    for (int i = 0; i < 45000; i++)
      step(($urandom % 10) < 9, ($urandom % 10) < 3);

    // Mid-period reset (R8).
    for (int i = 0; i < 1500; i++) step(1'b1, 1'b1);
    do_reset();
    phase = "R8";
    for (int i = 0; i < N - 1; i++) step(($urandom % 4) != 0, 1'b1);
    check("R8 no strobe before full period", int'(code_new), 0);
    step(1'b0, 1'b1);
    check("R8 strobe after full period", int'(code_new), 1);
    phase = "R4";
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);

    check("R3 captures seen", int'(captures >= 7), 1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule